// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block forms addresses for a 64-bit datapath from a base and an index. It covers the usual scaled-index patterns: the index is shifted left by one, two or three places (element sizes of 2, 4 or 8 bytes) and then added to the base. All sums wrap modulo 2^64. A second group of operations treats the index as an unsigned 32-bit word. These operations zero-extend the low half of operand A before they use it: a scaled add, a plain add, and a left shift by an immediate amount whose bits past bit 63 are lost.

The word-index operations are only legal when the datapath runs in its full 64-bit mode. If an operation is not supported, the block returns zero and raises an illegal flag. The operation code, the operands and the mode are captured together. The result and the flag appear as registered outputs one clock after the inputs are presented.

Top module: `scaled_index_agu`

## Requirements
- R1: With op_i = 0, 1 or 2 the result is (A << 1) + B, (A << 2) + B or (A << 3) + B, truncated to 64 bits. These three codes are legal in either mode.
- R2: With op_i = 3, 4 or 5 and wide_mode_i = 1 the result is (Z << 1) + B, (Z << 2) + B or (Z << 3) + B, modulo 2^64. Here Z is A[31:0] zero-extended to 64 bits.
- R3: With op_i = 6 and wide_mode_i = 1 the result is Z + B modulo 2^64.
- R4: With op_i = 7 and wide_mode_i = 1 the result is Z shifted left by shamt_i (0..63), with every bit beyond bit 63 dropped. Operand B and A[63:32] have no effect on this result.
- R5: With wide_mode_i = 0, codes 3 to 7 are illegal: illegal_o is 1 and result_o is 0.
- R6: Codes 8 to 15 are illegal in either mode: illegal_o is 1 and result_o is 0. illegal_o is 0 for every legal code.
- R7: Outputs are registered. The values presented before a rising clock edge appear on result_o and illegal_o after that edge, and they do not change before it.
- R8: A synchronous active-low reset clears result_o to 0 and illegal_o to 0.
- R9: A set bit 31 in A never spreads into the bits above the shifted word in codes 3 to 7. Operand A is zero-extended, never sign-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode_i | input | 1 | 1 when the datapath runs in 64-bit mode |
| op_i | input | 4 | Operation code (0..7 legal, see requirements) |
| a_i | input | 64 | Index operand A |
| b_i | input | 64 | Base operand B |
| shamt_i | input | 6 | Immediate shift amount for code 7 |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered illegal-operation flag |

## Verification
Two behaviours meet in the same cycle. The zero-extension of A's low word and the modulo-2^64 wrap of the adder both act on a word-index scaled add. The bench provokes this by setting bit 31 of A, filling A's upper half with ones and putting B near all-ones. With sign-extension the upper result bits would differ; without the wrap they would carry out. The expected sum is computed in the bench from the zero-extended word, and both outputs are compared one cycle later. Illegal codes in both modes are mixed into the random stream.

// File: rtl/sia_pkg.sv
// Shared operation codes and decoded control for the scaled-index address generator.
package sia_pkg;

    localparam int OP_W = 4;

    // Operation codes; values 8..15 are unsupported.
    typedef enum logic [OP_W-1:0] {
        OP_SCALE1  = 4'd0,
        OP_SCALE2  = 4'd1,
        OP_SCALE3  = 4'd2,
        OP_WSCALE1 = 4'd3,
        OP_WSCALE2 = 4'd4,
        OP_WSCALE3 = 4'd5,
        OP_WADD    = 4'd6,
        OP_WSHL    = 4'd7
    } sia_op_e;

    // Decoded control word steering the datapath.
    typedef struct packed {
        logic       legal;
        logic       zext_a;
        logic [1:0] scale;
        logic       sel_shl;
    } sia_ctrl_t;

endpackage

// File: rtl/sia_decode.sv
// Operation decoder.
// Turns the operation code and datapath mode into a control word.
// Assumes word-index codes are legal only in 64-bit mode; unknown codes are illegal.
module sia_decode
    import sia_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            wide_mode_i,
    output sia_ctrl_t       ctrl_o
);

    // Map each code to its scale, extension and result source.
    always_comb begin
        ctrl_o = '0;
        case (op_i)
            OP_SCALE1:  begin ctrl_o.legal = 1'b1; ctrl_o.scale = 2'd1; end
            OP_SCALE2:  begin ctrl_o.legal = 1'b1; ctrl_o.scale = 2'd2; end
            OP_SCALE3:  begin ctrl_o.legal = 1'b1; ctrl_o.scale = 2'd3; end
            OP_WSCALE1: begin ctrl_o.legal = wide_mode_i; ctrl_o.zext_a = 1'b1; ctrl_o.scale = 2'd1; end
            OP_WSCALE2: begin ctrl_o.legal = wide_mode_i; ctrl_o.zext_a = 1'b1; ctrl_o.scale = 2'd2; end
            OP_WSCALE3: begin ctrl_o.legal = wide_mode_i; ctrl_o.zext_a = 1'b1; ctrl_o.scale = 2'd3; end
            OP_WADD:    begin ctrl_o.legal = wide_mode_i; ctrl_o.zext_a = 1'b1; ctrl_o.scale = 2'd0; end
            OP_WSHL:    begin ctrl_o.legal = wide_mode_i; ctrl_o.zext_a = 1'b1; ctrl_o.sel_shl = 1'b1; end
            default:    ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/sia_scaled_add.sv
// Scaled adder: (X << scale) + B modulo 2^DATA_W, with X either A or A's zero-extended low word.
// Assumes scale never exceeds MAX_SCALE; candidate shifts are built by generate.
module sia_scaled_add #(
    parameter int DATA_W    = 64,
    parameter int WORD_W    = 32,
    parameter int MAX_SCALE = 3,
    localparam int SCALE_W  = $clog2(MAX_SCALE + 1)
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic               zext_a_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [DATA_W-1:0]  sum_o
);

    logic [DATA_W-1:0] a_src;
    logic [DATA_W-1:0] cand [MAX_SCALE+1];
    logic [DATA_W-1:0] scaled;

    // Choose the full operand or its zero-extended low word.
    always_comb begin
        a_src = zext_a_i ? {{(DATA_W-WORD_W){1'b0}}, a_i[WORD_W-1:0]} : a_i;
    end

    // One fixed-distance shift per supported scale.
    for (genvar s = 0; s <= MAX_SCALE; s++) begin : g_cand
        assign cand[s] = a_src << s;
    end

    // Pick the shifted operand for the requested scale.
    always_comb begin
        scaled = cand[0];
        for (int s = 1; s <= MAX_SCALE; s++) begin
            if (scale_i == SCALE_W'(s)) scaled = cand[s];
        end
    end

    // Wrapping sum.
    always_comb begin
        sum_o = scaled + b_i;
    end

endmodule

// File: rtl/sia_word_shl.sv
// Logarithmic left shifter of a zero-extended word.
// Places the WORD_W-bit input at bit position shamt; bits past DATA_W-1 are lost.
// Assumes DATA_W is a power of two so shamt spans 0..DATA_W-1.
module sia_word_shl #(
    parameter int DATA_W   = 64,
    parameter int WORD_W   = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [WORD_W-1:0]  word_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DATA_W-1:0]  shl_o
);

    logic [DATA_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = {{(DATA_W-WORD_W){1'b0}}, word_i};

    // Each stage shifts by a power of two under one bit of the amount.
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        assign stage[k+1] = shamt_i[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign shl_o = stage[SHAMT_W];

endmodule

// File: rtl/scaled_index_agu.sv
// Scaled-index address generator, top level.
// Decodes the operation, forms either a scaled sum or a shifted word, and registers
// the result with an illegal flag. Assumes one operation per cycle; output latency is one clock.
module scaled_index_agu
    import sia_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int WORD_W    = 32,
    parameter int MAX_SCALE = 3,
    localparam int SHAMT_W  = $clog2(DATA_W),
    localparam int SCALE_W  = $clog2(MAX_SCALE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_mode_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               illegal_o
);

    sia_ctrl_t         ctrl;
    logic [DATA_W-1:0] sum_val;
    logic [DATA_W-1:0] shl_val;
    logic [DATA_W-1:0] next_val;

    sia_decode i_decode (
        .op_i        (op_i),
        .wide_mode_i (wide_mode_i),
        .ctrl_o      (ctrl)
    );

    sia_scaled_add #(
        .DATA_W    (DATA_W),
        .WORD_W    (WORD_W),
        .MAX_SCALE (MAX_SCALE)
    ) i_add (
        .a_i      (a_i),
        .b_i      (b_i),
        .zext_a_i (ctrl.zext_a),
        .scale_i  (SCALE_W'(ctrl.scale)),
        .sum_o    (sum_val)
    );

    sia_word_shl #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) i_shl (
        .word_i  (a_i[WORD_W-1:0]),
        .shamt_i (shamt_i),
        .shl_o   (shl_val)
    );

    // Select the result source, forcing zero for illegal operations.
    always_comb begin
        if (!ctrl.legal)       next_val = '0;
        else if (ctrl.sel_shl) next_val = shl_val;
        else                   next_val = sum_val;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= next_val;
            illegal_o <= !ctrl.legal;
        end
    end

endmodule

// File: rtl/scaled_index_agu_chk.sv
// Property checker for scaled_index_agu, attached by bind.
module scaled_index_agu_chk
    import sia_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int WORD_W   = 32,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wide_mode_i,
    input logic [OP_W-1:0]    op_i,
    input logic [DATA_W-1:0]  a_i,
    input logic [DATA_W-1:0]  b_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [DATA_W-1:0]  result_o,
    input logic               illegal_o
);

    localparam int HI_W = DATA_W - WORD_W;

    a_r1_scale_by_two: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SCALE1) |=> (result_o == (($past(a_i) << 1) + $past(b_i))) && !illegal_o);

    a_r1_scale_by_eight: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SCALE3) |=> (result_o == (($past(a_i) << 3) + $past(b_i))));

    a_r2_word_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WSCALE2 && wide_mode_i) |=>
        (result_o == (({{HI_W{1'b0}}, $past(a_i[WORD_W-1:0])} << 2) + $past(b_i))));

    a_r3_word_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WADD && wide_mode_i) |=>
        (result_o == ({{HI_W{1'b0}}, $past(a_i[WORD_W-1:0])} + $past(b_i))));

    a_r4_word_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WSHL && wide_mode_i) |=>
        (result_o == ({{HI_W{1'b0}}, $past(a_i[WORD_W-1:0])} << $past(shamt_i))));

    a_r5_narrow_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode_i && op_i >= OP_WSCALE1 && op_i <= OP_WSHL) |=> illegal_o && (result_o == '0));

    a_r6_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[OP_W-1]) |=> illegal_o);

    a_r6_zero_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (result_o == '0));

    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0) && !illegal_o);

endmodule

bind scaled_index_agu scaled_index_agu_chk #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_mode_i (wide_mode_i),
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .shamt_i     (shamt_i),
    .result_o    (result_o),
    .illegal_o   (illegal_o)
);

// File: tb/test_scaled_index_agu.sv
module test_scaled_index_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode_i = 1'b1;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [5:0]  shamt_i = '0;
    logic [63:0] result_o;
    logic        illegal_o;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    scaled_index_agu i_scaled_index_agu (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_mode_i (wide_mode_i),
        .op_i        (op_i),
        .a_i         (a_i),
        .b_i         (b_i),
        .shamt_i     (shamt_i),
        .result_o    (result_o),
        .illegal_o   (illegal_o)
    );

    // Reference model from the requirements: {illegal, result}.
    function automatic logic [64:0] model(input logic [3:0] op, input logic [63:0] a,
                                          input logic [63:0] b, input logic [5:0] sh,
                                          input logic wide);
        logic [63:0] z;
        z = {32'h0, a[31:0]};
        case (op)
            4'd0: return {1'b0, (a << 1) + b};
            4'd1: return {1'b0, (a << 2) + b};
            4'd2: return {1'b0, (a << 3) + b};
            4'd3: return wide ? {1'b0, (z << 1) + b} : {1'b1, 64'h0};
            4'd4: return wide ? {1'b0, (z << 2) + b} : {1'b1, 64'h0};
            4'd5: return wide ? {1'b0, (z << 3) + b} : {1'b1, 64'h0};
            4'd6: return wide ? {1'b0, z + b}        : {1'b1, 64'h0};
            4'd7: return wide ? {1'b0, z << sh}      : {1'b1, 64'h0};
            default: return {1'b1, 64'h0};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic wide);
        if (op >= 4'd8) return "R6";
        if (op >= 4'd3 && !wide) return "R5";
        if (op <= 4'd2) return "R1";
        if (op <= 4'd5) return "R2";
        if (op == 4'd6) return "R3";
        return "R4";
    endfunction

    task automatic compare(input string req, input logic [63:0] exp_r, input logic exp_ill);
        n_run++;
        if (result_o !== exp_r || illegal_o !== exp_ill) begin
            n_fail++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     req, result_o, illegal_o, exp_r, exp_ill);
        end
    endtask

    // Drive one operation, let it register, then check.
    task automatic run_op(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                          input logic [5:0] sh, input logic wide, input string req);
        logic [64:0] e;
        op_i = op; a_i = a; b_i = b; shamt_i = sh; wide_mode_i = wide;
        e = model(op, a, b, sh, wide);
        @(posedge clk); #1;
        compare(req.len() ? req : req_of(op, wide), e[63:0], e[64]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb, prev;
        void'($urandom(32'h5EED_0A61));
        // R8: inputs that would give a nonzero result are held during reset.
        op_i = 4'd0; a_i = 64'h1234; b_i = 64'h1; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare("R8", 64'h0, 1'b0);
        rst_n = 1'b1;

        // R1 wrap at the top of the range.
        run_op(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h9, 6'd0, 1'b1, "R1");
        run_op(4'd0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 6'd0, 1'b0, "R1");
        // R9 with R2: bit 31 set, upper ones, B near all-ones (wrap and zero-extension together).
        run_op(4'd3, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0000, 6'd0, 1'b1, "R9");
        run_op(4'd5, 64'hDEAD_BEEF_FFFF_FFFF, 64'hFFFF_FFF8_0000_0009, 6'd0, 1'b1, "R9");
        // R3 with bit 31 set.
        run_op(4'd6, 64'hFFFF_FFFF_8000_0000, 64'h1, 6'd0, 1'b1, "R9");
        // R4 boundaries: shift 0, 32, 63, and a shift that clips the word.
        run_op(4'd7, 64'hFFFF_FFFF_8000_0001, 64'hFFFF, 6'd0,  1'b1, "R4");
        run_op(4'd7, 64'hFFFF_FFFF_8000_0001, 64'h0,    6'd32, 1'b1, "R4");
        run_op(4'd7, 64'h0000_0000_FFFF_FFFF, 64'h0,    6'd63, 1'b1, "R4");
        run_op(4'd7, 64'h0000_0000_ABCD_1234, 64'h0,    6'd40, 1'b1, "R4");
        // R5 and R6 illegal cases.
        run_op(4'd7, 64'h1, 64'h2, 6'd3, 1'b0, "R5");
        run_op(4'd6, 64'h1, 64'h2, 6'd3, 1'b0, "R5");
        run_op(4'd8, 64'h1, 64'h2, 6'd3, 1'b1, "R6");
        run_op(4'd15, 64'hFFFF, 64'h2, 6'd3, 1'b0, "R6");
        // R7: result holds until the next edge after an input change.
        run_op(4'd1, 64'h10, 64'h3, 6'd0, 1'b1, "R1");
        prev = 64'h43;
        op_i = 4'd0; a_i = 64'h5; b_i = 64'h0;
        #2;
        compare("R7", prev, 1'b0);
        @(posedge clk); #1;
        compare("R7", 64'hA, 1'b0);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            logic       wd;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) ra[31] = 1'b1;
            op = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(8, 15)) : 4'($urandom_range(0, 7));
            wd = ($urandom_range(0, 4) != 0);
            run_op(op, ra, rb, 6'($urandom_range(0, 63)), wd, "");
        end

        // R8: reset in mid-run clears the outputs.
        run_op(4'd8, 64'h0, 64'h0, 6'd0, 1'b1, "R6");
        rst_n = 1'b0;
        @(posedge clk); #1;
        compare("R8", 64'h0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule